// File: doc/BRIEF.md
# Single-Source Interrupt Request Controller

This block turns one raw external input pin into a prioritized interrupt request. All of its setup lives in one 8-bit control/status register on a simple synchronous bus. The register selects the active polarity of the pin, edge or level detection, an enable gate, and a 3-bit priority level that is driven out with the request.

The pin first passes through a synchronizer. It is then made active-high according to the polarity bit. In level mode the status bit follows this conditioned signal. In edge mode the status bit latches an inactive-to-active transition and holds it until software writes the clear bit.

A clear in a write cycle also absorbs any transition that the same write would create by changing polarity or mode. Software can therefore reconfigure the block without taking a false interrupt. The request output is free of acknowledge: it stays asserted while status, enable and a nonzero level all hold.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset, read data is 0x00, the request output is 0 and the level output is 0.
- R2: Register layout: bit 7 is polarity, bit 6 is mode (1 = edge, 0 = level), bit 5 is status, bit 4 is enable, bit 3 is clear and bits 2..0 are the level. Status is read-only, so a write of bit 5 has no effect. The clear bit always reads 0. The other fields read back what was written.
- R3: The pin passes through a two-flop synchronizer. A pin change driven before a rising clock edge first shows in status after the third rising edge.
- R4: With polarity 0, a high level or rising edge of the pin is active. With polarity 1, a low level or falling edge is active.
- R5: In level mode, status follows the conditioned pin. When the pin goes inactive, status returns to 0. A write with the clear bit set (bit 3 = 1, bit 6 = 0) leaves status unchanged.
- R6: In edge mode, status is set by an inactive-to-active transition of the conditioned pin. It stays 1 after the pin returns inactive.
- R7: A write with bit 6 = 1 and bit 3 = 1 leaves status at 0 after that write. The clear wins over any transition detected in the same cycle. It also cancels any transition that the polarity written in that same write would cause.
- R8: In edge mode, a write that changes polarity without the clear bit, and so turns the conditioned pin active, sets status one cycle after the register updates.
- R9: The request output is 1 exactly when status, enable and a nonzero level are all set. The level output then carries the programmed level; otherwise it is 0. A level of 0 never requests.
- R10: Status records the pin condition whether or not enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| pin_in | input | 1 | Raw asynchronous interrupt source pin |
| irq_level | output | 3 | Priority level of the active request, 0 when idle |
| irq_req | output | 1 | Interrupt request valid |

## Verification
The bench sweeps every combination of polarity, mode, enable and level. For each one it drives the pin active and then inactive, and checks readback, status, request and level against values computed from the configuration. These checks catch:
- a design that lets level 0 or a cleared enable raise a request;
- a design that drops latched edge status when the pin releases;
- a design that honours clear in level mode.

It also provokes the polarity-flip spurious edge both with and without the clear bit. A design that checks the clear against the old polarity, or lets a same-cycle transition beat the clear, leaves status set when it should be 0. A latency check at the synchronizer catches a missing or extra flop.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int REG_W  = 8;
    localparam int LVL_W  = 3;
    localparam int B_POL  = 7;
    localparam int B_MODE = 6;
    localparam int B_STAT = 5;
    localparam int B_EN   = 4;
    localparam int B_CLR  = 3;

    typedef struct packed {
        logic             pol;
        logic             mode;
        logic             status;
        logic             ien;
        logic [LVL_W-1:0] lvl;
    } csr_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_comb sh_d[i] = async_in;
        end else begin : g_next
            always_comb sh_d[i] = sh_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= sh_d[i];
        end
    end

    assign sync_out = sh_q[STAGES-1];

    // R3: the output is the input delayed by the full chain
    p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q[0] |=> sh_q[1]);
endmodule

// File: rtl/irq_cond_detect.sv
module irq_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pol_q,
    input  logic rebase,
    input  logic rebase_pol,
    output logic cond,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        cond   = sync_in ^ pol_q;
        rise   = cond & ~prev_q;
        prev_d = rebase ? (sync_in ^ rebase_pol) : cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R7: after a rebase the stored history matches the new polarity
    p_rebase_history_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rebase |=> prev_q == ($past(sync_in) ^ $past(rebase_pol)));
endmodule

// File: rtl/irq_csr.sv
module irq_csr
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             cond,
    input  logic             rise,
    output csr_t             csr_q,
    output logic             rebase,
    output logic             rebase_pol
);
    csr_t csr_d;
    logic clr_hit;

    always_comb begin
        csr_d      = csr_q;
        clr_hit    = wr_en & wdata[B_CLR] & wdata[B_MODE];
        rebase     = clr_hit;
        rebase_pol = wdata[B_POL];
        if (wr_en) begin
            csr_d.pol  = wdata[B_POL];
            csr_d.mode = wdata[B_MODE];
            csr_d.ien  = wdata[B_EN];
            csr_d.lvl  = wdata[LVL_W-1:0];
        end
        if (clr_hit)         csr_d.status = 1'b0;
        else if (csr_d.mode) csr_d.status = csr_q.status | rise;
        else                 csr_d.status = cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    // R7: an edge-mode clear always leaves status low
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[B_CLR] && wdata[B_MODE]) |=> !csr_q.status);
    // R5: level mode tracks the conditioned pin
    p_level_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_q.mode && !wr_en) |=> csr_q.status == $past(cond));
    // R6: edge status holds until cleared
    p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q.mode && csr_q.status && !wr_en) |=> csr_q.status);
    // R6: a detected edge sets status
    p_edge_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q.mode && rise && !wr_en) |=> csr_q.status);
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             pin_in,
    output logic [LVL_W-1:0] irq_level,
    output logic             irq_req
);
    csr_t csr_q;
    logic pin_s, cond, rise, rebase, rebase_pol;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_s)
    );

    irq_cond_detect u_det (
        .clk(clk), .rst_n(rst_n), .sync_in(pin_s), .pol_q(csr_q.pol),
        .rebase(rebase), .rebase_pol(rebase_pol), .cond(cond), .rise(rise)
    );

    irq_csr u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
        .cond(cond), .rise(rise), .csr_q(csr_q),
        .rebase(rebase), .rebase_pol(rebase_pol)
    );

    always_comb begin
        rdata         = '0;
        rdata[B_POL]  = csr_q.pol;
        rdata[B_MODE] = csr_q.mode;
        rdata[B_STAT] = csr_q.status;
        rdata[B_EN]   = csr_q.ien;
        rdata[LVL_W-1:0] = csr_q.lvl;
        irq_req   = csr_q.status & csr_q.ien & (csr_q.lvl != '0);
        irq_level = irq_req ? csr_q.lvl : '0;
    end

    // R9: a request always carries a nonzero level
    p_req_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_level != '0);
    // R9: an idle output never shows a level
    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_level == '0);
    // R2: the clear bit never reads back as set
    p_clr_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[B_CLR] == 1'b0);
endmodule

// File: tb/irq_src_ctrl_test.sv
module irq_src_ctrl_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       pin_in = 0;
    logic [2:0] irq_level;
    logic       irq_req;
    int checks = 0;
    int fails  = 0;
    bit done = 0;

    irq_src_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .irq_level(irq_level),
        .irq_req(irq_req)
    );

    always #10 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wdata = d;
        @(negedge clk);
        wr_en = 0; wdata = 0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string req, input bit pol, input bit md,
                            input bit st, input bit en, input int lvl);
        bit r;
        r = st && en && (lvl != 0);
        chk({req, " rdata"}, rdata, {pol, md, st, en, 1'b0, lvl[2:0]});
        chk({req, " req"}, irq_req, r);
        chk({req, " level"}, irq_level, r ? lvl : 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(2);
        // R1 reset state
        chk("R1 rdata", rdata, 0);
        chk("R1 req", irq_req, 0);
        chk("R1 level", irq_level, 0);
        rst_n = 1;
        tick(2);

        // R3 latency: level mode, polarity 0, enable, level 5
        wr(8'h15);
        tick(3);
        pin_in = 1;
        tick(2);
        chk("R3 not yet", rdata[5], 0);
        tick(1);
        chk("R3 third edge", rdata[5], 1);
        pin_in = 0;
        tick(3);

        // R2 R4 R5 R6 R7 R9 R10 sweep
        for (int pol = 0; pol < 2; pol++)
            for (int md = 0; md < 2; md++)
                for (int en = 0; en < 2; en++)
                    for (int lvl = 0; lvl < 8; lvl++) begin
                        logic [7:0] cfg;
                        cfg = {pol[0], md[0], 1'b1, en[0], 1'b1, lvl[2:0]};
                        pin_in = pol[0];
                        tick(3);
                        wr(cfg);
                        tick(2);
                        chk_outs("R2 idle", pol[0], md[0], 0, en[0], lvl);
                        pin_in = ~pol[0];
                        tick(3);
                        chk_outs("R4 R10 active", pol[0], md[0], 1, en[0], lvl);
                        pin_in = pol[0];
                        tick(3);
                        if (md == 1) begin
                            chk_outs("R6 held", pol[0], 1, 1, en[0], lvl);
                            wr(cfg);
                            chk_outs("R7 cleared", pol[0], 1, 0, en[0], lvl);
                        end else begin
                            chk_outs("R5 released", pol[0], 0, 0, en[0], lvl);
                            pin_in = ~pol[0];
                            tick(3);
                            wr(cfg);
                            chk_outs("R5 clear ignored", pol[0], 0, 1, en[0], lvl);
                        end
                    end

        // R8 spurious edge from a polarity flip without clear
        pin_in = 0;
        tick(3);
        wr(8'h5F);          // edge, pol 0, clear
        tick(2);
        chk("R8 base", rdata[5], 0);
        wr(8'hD7);          // pol 1, edge, no clear
        tick(1);
        chk("R8 spurious set", rdata[5], 1);
        chk("R8 req", irq_req, 1);

        // R7 same flip with clear is absorbed
        wr(8'h5F);          // back to pol 0 with clear
        tick(2);
        chk("R7 base", rdata[5], 0);
        wr(8'hDF);          // pol 1, edge, clear
        tick(3);
        chk("R7 flip absorbed", rdata[5], 0);
        chk("R7 no req", irq_req, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule